// File: doc/BRIEF.md
# Register-programmed raster timing generator

This block produces the raster timing for a display pixel pipeline. It runs on the pixel clock and is set up through a small 32-bit register window addressed by byte offset. Software writes the frame totals, the blanking widths, the positions of the horizontal and vertical sync pulses, the sync polarities, the pixel format and an enable bit. While enabled, the block scans a horizontal and a vertical counter over the frame. From them it derives hsync, vsync, a data-enable window, the current pixel coordinates and a one-pixel frame-start strobe.

Geometry is stored in minus-one form, with a horizontal half and a vertical half in each word. Sync edges are given as offsets past the end of the active region, not as absolute counter positions. While the block scans, geometry writes are held back until the frame wraps, so a frame never mixes two geometries. Buffer address and stride reach the fetch side only after a start-set request, and they take effect on the following frame start.

Top module: `vtg_core`

## Requirements
- R1: Register reads return data one clock after the read strobe. Format 0x10, blanking 0x1C, hsync 0x14, vsync 0x18, buffer 0x40 and stride 0x50 read back the value written. Control 0x00 reads back only bits 4:1. ID 0x3FC returns parameter ID_VAL. Start-set 0x84 and all unmapped offsets read zero.
- R2: While control bit 1 (enable) is clear, px_x and px_y are zero, de and frame_start are low, and hsync and vsync sit at their inactive levels.
- R3: On the first clock after enable is written, the position is (0,0). px_x then steps by one each clock and wraps to 0 after H_total-1, where H_total is format bits 31:16 plus one. px_y steps at each line wrap and wraps to 0 after V_total-1, where V_total is format bits 15:0 plus one.
- R4: de is high exactly when px_x < H_total-H_blank and px_y < V_total-V_blank. H_blank is blanking bits 31:16 plus one and V_blank is blanking bits 15:0 plus one.
- R5: With A the active width, hsync is active for A+S <= px_x < A+E, where S is hsync bits 31:16 plus one and E is hsync bits 15:0 plus one. vsync is defined the same way from the vsync register and the active height. Control bit 4 (hsync) and bit 3 (vsync) give active-high when set and active-low when clear, and take effect at once.
- R6: frame_start is high for exactly the pixel at position (0,0) of each enabled frame.
- R7: Status bit 1 (busy) reads 1 while enabled and 0 while disabled, and all other status bits read 0.
- R8: While enabled, writes to the format, blanking and sync registers take effect at the frame wrap after the write. While disabled, they take effect at once.
- R9: fb_base and fb_pitch change only when a 1 is written to start-set. They then load the written buffer and stride values on the clock after the next frame_start.
- R10: pix_wide follows control bit 2 (1 = 32-bit XRGB, 0 = 16-bit RGB565).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| hsync | output | 1 | Horizontal sync, polarity from control |
| vsync | output | 1 | Vertical sync, polarity from control |
| de | output | 1 | Active-area data enable |
| px_x | output | 16 | Current pixel column |
| px_y | output | 16 | Current line |
| frame_start | output | 1 | High at pixel (0,0) of each frame |
| fb_base | output | 32 | Buffer address in use by fetch |
| fb_pitch | output | 32 | Stride in use by fetch |
| pix_wide | output | 1 | Pixel format select |

## Verification
The assertions assume a sane geometry: each total is at least two, the blanking width is smaller than the total, and the sync offsets fall inside the blanking interval, so the 16-bit sums never wrap. The stimulus keeps to this. It uses a 10x6 frame with 4 pixels and 2 lines of blanking, then widens the line to 12 pixels while scanning. Sync and start-set writes are placed mid-frame, away from the wrap cycle, so no write lands on a shadow-load edge.

// File: rtl/vtg_core.sv
module vtg_core #(
  parameter int AW = 12,
  parameter logic [31:0] ID_VAL = 32'h5647_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [15:0]   px_x,
  output logic [15:0]   px_y,
  output logic          frame_start,
  output logic [31:0]   fb_base,
  output logic [31:0]   fb_pitch,
  output logic          pix_wide
);
  localparam logic [AW-1:0] A_CTRL = AW'('h000);
  localparam logic [AW-1:0] A_STAT = AW'('h004);
  localparam logic [AW-1:0] A_FMT  = AW'('h010);
  localparam logic [AW-1:0] A_HS   = AW'('h014);
  localparam logic [AW-1:0] A_VS   = AW'('h018);
  localparam logic [AW-1:0] A_BLK  = AW'('h01C);
  localparam logic [AW-1:0] A_BASE = AW'('h040);
  localparam logic [AW-1:0] A_PTCH = AW'('h050);
  localparam logic [AW-1:0] A_SSET = AW'('h084);
  localparam logic [AW-1:0] A_ID   = AW'('h3FC);

  logic [4:1]  ctrl_q;
  logic [31:0] r_fmt, r_hs, r_vs, r_blk, r_base, r_pitch;
  logic [31:0] sh_fmt, sh_hs, sh_vs, sh_blk;
  logic [15:0] xcnt, ycnt;
  logic        pend;

  wire en = ctrl_q[1];
  wire [15:0] h_last = sh_fmt[31:16];
  wire [15:0] v_last = sh_fmt[15:0];
  wire [15:0] hact = sh_fmt[31:16] - sh_blk[31:16];
  wire [15:0] vact = sh_fmt[15:0]  - sh_blk[15:0];
  wire [15:0] hs_a = hact + sh_hs[31:16] + 16'd1;
  wire [15:0] hs_b = hact + sh_hs[15:0]  + 16'd1;
  wire [15:0] vs_a = vact + sh_vs[31:16] + 16'd1;
  wire [15:0] vs_b = vact + sh_vs[15:0]  + 16'd1;
  wire line_end = xcnt == h_last;
  wire wrap = en && line_end && ycnt == v_last;

  wire hs_on = en && xcnt >= hs_a && xcnt < hs_b;
  wire vs_on = en && ycnt >= vs_a && ycnt < vs_b;

  assign hsync = hs_on ? ctrl_q[4] : ~ctrl_q[4];
  assign vsync = vs_on ? ctrl_q[3] : ~ctrl_q[3];
  assign de = en && xcnt < hact && ycnt < vact;
  assign px_x = en ? xcnt : 16'd0;
  assign px_y = en ? ycnt : 16'd0;
  assign frame_start = en && xcnt == 16'd0 && ycnt == 16'd0;
  assign pix_wide = ctrl_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      r_fmt <= '0; r_hs <= '0; r_vs <= '0; r_blk <= '0;
      r_base <= '0; r_pitch <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl_q  <= bus_wdata[4:1];
        A_FMT:  r_fmt   <= bus_wdata;
        A_HS:   r_hs    <= bus_wdata;
        A_VS:   r_vs    <= bus_wdata;
        A_BLK:  r_blk   <= bus_wdata;
        A_BASE: r_base  <= bus_wdata;
        A_PTCH: r_pitch <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_fmt <= '0; sh_hs <= '0; sh_vs <= '0; sh_blk <= '0;
    end else if (!en || wrap) begin
      sh_fmt <= r_fmt; sh_hs <= r_hs; sh_vs <= r_vs; sh_blk <= r_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      xcnt <= '0;
      ycnt <= '0;
    end else if (line_end) begin
      xcnt <= '0;
      ycnt <= (ycnt == v_last) ? 16'd0 : ycnt + 16'd1;
    end else begin
      xcnt <= xcnt + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      fb_base <= '0;
      fb_pitch <= '0;
    end else begin
      if (bus_wr && bus_addr == A_SSET && bus_wdata[0]) pend <= 1'b1;
      else if (frame_start) pend <= 1'b0;
      if (frame_start && pend) begin
        fb_base <= r_base;
        fb_pitch <= r_pitch;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= {27'd0, ctrl_q, 1'b0};
        A_STAT:  bus_rdata <= {30'd0, en, 1'b0};
        A_FMT:   bus_rdata <= r_fmt;
        A_HS:    bus_rdata <= r_hs;
        A_VS:    bus_rdata <= r_vs;
        A_BLK:   bus_rdata <= r_blk;
        A_BASE:  bus_rdata <= r_base;
        A_PTCH:  bus_rdata <= r_pitch;
        A_ID:    bus_rdata <= ID_VAL;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        hs_pol,
  input logic        vs_pol,
  input logic [15:0] h_last,
  input logic [15:0] px_x,
  input logic [15:0] px_y,
  input logic        hsync,
  input logic        vsync,
  input logic        de,
  input logic        frame_start
);
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (px_x == 16'd0 && px_y == 16'd0 && !de && !frame_start));

  // R2
  idle_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (hsync == !hs_pol && vsync == !vs_pol));

  // R3
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && px_x != h_last) |=> (!en || px_x == $past(px_x) + 16'd1));

  // R3
  x_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && px_x == h_last) |=> (!en || px_x == 16'd0));

  // R6
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

bind vtg_core vtg_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q[1]), .hs_pol(ctrl_q[4]), .vs_pol(ctrl_q[3]),
  .h_last(sh_fmt[31:16]), .px_x(px_x), .px_y(px_y), .hsync(hsync), .vsync(vsync),
  .de(de), .frame_start(frame_start)
);

// File: tb/vtg_core_bench.sv
module vtg_core_bench;
  localparam logic [31:0] ID = 32'h5647_0001;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bus_wr, bus_rd, hsync, vsync, de, frame_start, pix_wide;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, fb_base, fb_pitch;
  logic [15:0] px_x, px_y;

  vtg_core #(.AW(12), .ID_VAL(ID)) u_vtg_core (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync), .vsync(vsync), .de(de),
    .px_x(px_x), .px_y(px_y), .frame_start(frame_start), .fb_base(fb_base),
    .fb_pitch(fb_pitch), .pix_wide(pix_wide));

  int total = 0, bad = 0;
  bit done = 0;

  // {write, addr, data, expected}
  localparam int NV = 20;
  localparam logic [76:0] TBL [NV] = '{
    {1'b1, 12'h010, 32'h0009_0005, 32'h0},
    {1'b1, 12'h01C, 32'h0003_0001, 32'h0},
    {1'b1, 12'h014, 32'h0000_0002, 32'h0},
    {1'b1, 12'h018, 32'h0000_0001, 32'h0},
    {1'b1, 12'h040, 32'h0000_A000, 32'h0},
    {1'b1, 12'h050, 32'h0000_0040, 32'h0},
    {1'b0, 12'h010, 32'h0, 32'h0009_0005},
    {1'b0, 12'h01C, 32'h0, 32'h0003_0001},
    {1'b0, 12'h014, 32'h0, 32'h0000_0002},
    {1'b0, 12'h018, 32'h0, 32'h0000_0001},
    {1'b0, 12'h040, 32'h0, 32'h0000_A000},
    {1'b0, 12'h050, 32'h0, 32'h0000_0040},
    {1'b0, 12'h004, 32'h0, 32'h0},
    {1'b0, 12'h3FC, 32'h0, ID},
    {1'b0, 12'h008, 32'h0, 32'h0},
    {1'b0, 12'h084, 32'h0, 32'h0},
    {1'b1, 12'h000, 32'hFFFF_FFE5, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0000_0004},
    {1'b1, 12'h000, 32'h0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0}
  };

  // bench model
  int ht = 10, nht = 10, vt = 6, hbl = 4, vbl = 2, hss = 1, hse = 3, vss = 1, vse = 2;
  int ex = 0, ey = 0;
  bit men = 0, hp = 0, vp = 0, mpend = 0;
  logic [31:0] mb = 0, mp = 0, wb = 32'hA000, wp = 32'h40;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  // compare at the current negedge, then advance one clock
  task automatic tick();
    int ha = ht - hbl, va = vt - vbl;
    logic eh, ev, ed, ef;
    if (men) begin
      ed = ex < ha && ey < va;
      eh = (ex >= ha + hss && ex < ha + hse) ? hp : !hp;
      ev = (ey >= va + vss && ey < va + vse) ? vp : !vp;
      ef = ex == 0 && ey == 0;
    end else begin
      ed = 0; eh = !hp; ev = !vp; ef = 0;
    end
    chk("R2 R3 R4 R5 R6 raster", {px_x, px_y, de, hsync, vsync, frame_start},
        {16'(men ? ex : 0), 16'(men ? ey : 0), ed, eh, ev, ef});
    chk("R9 fb", {fb_base, fb_pitch}, {mb, mp});
    if (men) begin
      if (ex == 0 && ey == 0 && mpend) begin mb = wb; mp = wp; mpend = 0; end
      if (ex == ht - 1) begin
        ex = 0;
        if (ey == vt - 1) begin ey = 0; ht = nht; end
        else ey++;
      end else ex++;
    end else ht = nht;
    @(negedge clk);
  endtask

  task automatic twr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset", {px_x, px_y, de, hsync, vsync, frame_start}, {32'd0, 4'b0110});
    chk("R9 reset fb", {fb_base, fb_pitch}, 64'd0);

    // R1 register table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i][76]) begin
        wr(TBL[i][75:64], TBL[i][63:32]);
        if (TBL[i][75:64] == 12'h000 && TBL[i][63:32] == 32'hFFFF_FFE5)
          chk("R10 pix_wide", pix_wide, 1'b1);
      end else begin
        rd(TBL[i][75:64], d);
        chk("R1 readback", d, TBL[i][31:0]);
      end
    end
    chk("R10 pix_wide clear", pix_wide, 1'b0);
    chk("R9 no start-set", {fb_base, fb_pitch}, 64'd0);

    // enable, active-high syncs
    wr(12'h000, 32'h0000_001A);
    men = 1; hp = 1; vp = 1; ex = 0; ey = 0;
    for (int i = 0; i < 130; i++) tick();

    // R7 busy while scanning
    bus_rd = 1; bus_addr = 12'h004; tick(); bus_rd = 0;
    chk("R7 busy", bus_rdata, 32'h2);

    // R9 start-set mid-frame
    while (ex != 3 || ey != 1) tick();
    twr(12'h040, 32'h0000_B000); wb = 32'hB000;
    twr(12'h050, 32'h0000_0100); wp = 32'h100;
    for (int i = 0; i < 10; i++) tick();
    twr(12'h084, 32'h1); mpend = 1;
    for (int i = 0; i < 80; i++) tick();
    chk("R9 loaded", {fb_base, fb_pitch}, {32'hB000, 32'h100});

    // R8 geometry change while enabled: wider line at next wrap
    while (ex != 2 || ey != 2) tick();
    twr(12'h010, 32'h000B_0005); nht = 12;
    for (int i = 0; i < 160; i++) tick();

    // R5 active-low syncs, immediate
    while (ex != 1 || ey != 0) tick();
    twr(12'h000, 32'h0000_0002); hp = 0; vp = 0;
    for (int i = 0; i < 80; i++) tick();

    // R2 disable
    twr(12'h000, 32'h0); men = 0;
    for (int i = 0; i < 6; i++) tick();
    rd(12'h004, d);
    chk("R7 idle status", d, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule